// File: doc/BRIEF.md
# Function Unit Operand and Result Handshake Controller

This block sequences one instruction through a single execution pipeline. A one-cycle issue pulse makes the unit busy. The unit then requests both source operands from the scoreboard side at once. Each operand is captured into the pipeline input register in the cycle its read grant arrives.

When both operands are held, the unit hands exactly one operation to the pipeline, which here is a 16-bit adder stub with a valid/ready handshake. The unit stores the returned sum in a holding register and then raises a write request. An active-low shadow input can stop that request from rising. The write grant drives the held sum onto the result port and returns the unit to idle.

A kill pulse clears every request, flushes the pipeline and discards the held sum at any point in the sequence.

Top module: `fu_handshake_ctrl`

## Requirements
- R1: In the cycle after issue_i is sampled high while idle and kill_i is low, busy_o is high and both rd_req_o bits (bit 0 for operand A, bit 1 for operand B) are high.
- R2: rd_req_o is all zero whenever busy_o is low.
- R3: When rd_req_o[i] and rd_grant_i[i] are both high at a clock edge, rd_req_o[i] is low in the next cycle. From then on, the matching pipeline input (alu_a_o for bit 0, alu_b_o for bit 1) holds the source value that was sampled at that edge. The operands may be granted in either order or in the same cycle.
- R4: Exactly one operation enters the pipeline per issue, after both operands are held. wr_req_o stays low until the pipeline result has been captured in the holding register.
- R5: While shadow_ni is low, wr_req_o cannot go from low to high. A wr_req_o that is already high stays high until it is granted or killed.
- R6: result_o equals (operand A + operand B) mod 2^16 in any cycle where wr_req_o and wr_grant_i are both high, and is zero in every other cycle.
- R7: In the cycle after a write grant, busy_o and wr_req_o are low and a new issue is accepted.
- R8: In the cycle after kill_i is sampled high, busy_o, rd_req_o and wr_req_o are all low. A later operation returns only its own sum. If kill_i and issue_i are high together while idle, the issue is dropped.
- R9: After reset, busy_o, rd_req_o, wr_req_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | One-cycle issue pulse, only while idle |
| kill_i | input | 1 | Abort the current sequence |
| shadow_ni | input | 1 | Active-low hold on raising the write request |
| src_a_i | input | 16 | Operand A source data |
| src_b_i | input | 16 | Operand B source data |
| rd_grant_i | input | 2 | Per-operand read grant |
| wr_grant_i | input | 1 | Write grant |
| busy_o | output | 1 | Unit holds an instruction |
| rd_req_o | output | 2 | Per-operand read request |
| wr_req_o | output | 1 | Write request |
| alu_a_o | output | 16 | Latched operand A at the pipeline input |
| alu_b_o | output | 16 | Latched operand B at the pipeline input |
| result_o | output | 16 | Held sum, driven only in the write-grant cycle |

## Verification
The bench varies the read grant delays per operand. This covers A first, B first and both in the same cycle, which shows whether each operand latch is tied to its own grant bit. Source buses carry random values outside grant cycles, so a latch that does not hold its captured value produces a wrong sum.

Shadow held low for several cycles before the result is ready tells a blocked rise apart from a late one. Shadow dropped after the request is already high shows that the request is kept. Kills at random points, followed by an unrelated operation, show whether a stale held sum or an in-flight pipeline result leaks into the next result. Operands such as 0xFFFF+1 check that the sum wraps.

// File: rtl/fu_hs_pkg.sv
package fu_hs_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/fu_operand_port.sv
module fu_operand_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          grant_i,
  input  logic [DW-1:0] src_i,
  output logic          req_o,
  output logic          got_o,
  output logic [DW-1:0] data_o
);
  logic          req_q, got_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign take = req_q & grant_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      got_q  <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      req_q <= 1'b0;
      got_q <= 1'b0;
    end else if (start_i) begin
      req_q <= 1'b1;
      got_q <= 1'b0;
    end else if (take) begin
      req_q  <= 1'b0;
      got_q  <= 1'b1;
      data_q <= src_i;
    end
  end

  assign req_o  = req_q;
  assign got_o  = got_q;
  assign data_o = data_q;

  AST_RD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && grant_i |=> !req_q); // R3
  AST_OPND_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && grant_i && !clr_i |=> data_q == $past(src_i)); // R3
endmodule

// File: rtl/fu_add_stub.sv
module fu_add_stub #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  logic          vld_q;
  logic [DW-1:0] sum_q;

  assign in_ready_o = ~vld_q | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      sum_q <= '0;
    end else if (flush_i) begin
      vld_q <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      vld_q <= 1'b1;
      sum_q <= a_i + b_i;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = sum_q;

  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !out_ready_i && !flush_i |=> vld_q && $stable(sum_q)); // R4
endmodule

// File: rtl/fu_result_hold.sv
module fu_result_hold #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_data_i,
  input  logic          shadow_ni,
  input  logic          wr_grant_i,
  output logic          res_vld_o,
  output logic          wr_req_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  logic          res_vld_q, wr_req_q;
  logic [DW-1:0] hold_q;
  logic          done;

  assign done = wr_req_q & wr_grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_q <= 1'b0;
      wr_req_q  <= 1'b0;
      hold_q    <= '0;
    end else if (clr_i || done) begin
      res_vld_q <= 1'b0;
      wr_req_q  <= 1'b0;
    end else begin
      if (cap_i) begin
        hold_q    <= cap_data_i;
        res_vld_q <= 1'b1;
      end
      // rise only when shadow released; once high, hold
      if (res_vld_q && shadow_ni) wr_req_q <= 1'b1;
    end
  end

  assign res_vld_o = res_vld_q;
  assign wr_req_o  = wr_req_q;
  assign done_o    = done;
  assign result_o  = done ? hold_q : '0;

  AST_SHADOW_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shadow_ni && !wr_req_q |=> !wr_req_q); // R5
  AST_SHADOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_q && !wr_grant_i && !clr_i |=> wr_req_q); // R5
  AST_WR_NEEDS_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_q |-> res_vld_q); // R4
endmodule

// File: rtl/fu_handshake_ctrl.sv
module fu_handshake_ctrl
  import fu_hs_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic               kill_i,
  input  logic               shadow_ni,
  input  logic [DW-1:0]      src_a_i,
  input  logic [DW-1:0]      src_b_i,
  input  logic [NUM_SRC-1:0] rd_grant_i,
  input  logic               wr_grant_i,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] rd_req_o,
  output logic               wr_req_o,
  output logic [DW-1:0]      alu_a_o,
  output logic [DW-1:0]      alu_b_o,
  output logic [DW-1:0]      result_o
);
  localparam int unsigned NS = NUM_SRC;

  logic          busy_q, sent_q;
  logic          issue_go, done;
  logic          alu_in_valid, alu_in_ready, alu_out_valid, alu_out_ready, cap;
  logic          res_vld;
  logic [DW-1:0] alu_sum;
  logic [NS-1:0] got, req;
  logic [DW-1:0] src  [NS];
  logic [DW-1:0] opnd [NS];

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  assign issue_go = issue_i & ~busy_q & ~kill_i;

  for (genvar gi = 0; gi < NS; gi++) begin : g_port
    fu_operand_port #(.DW(DW)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (issue_go),
      .clr_i   (kill_i | done),
      .grant_i (rd_grant_i[gi]),
      .src_i   (src[gi]),
      .req_o   (req[gi]),
      .got_o   (got[gi]),
      .data_o  (opnd[gi])
    );
  end

  // one operation per issue
  assign alu_in_valid  = busy_q & (&got) & ~sent_q & ~kill_i;
  assign alu_out_ready = busy_q & ~res_vld;
  assign cap           = alu_out_valid & alu_out_ready & ~kill_i;

  fu_add_stub #(.DW(DW)) u_alu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (kill_i),
    .in_valid_i  (alu_in_valid),
    .in_ready_o  (alu_in_ready),
    .a_i         (opnd[0]),
    .b_i         (opnd[1]),
    .out_valid_o (alu_out_valid),
    .out_ready_i (alu_out_ready),
    .out_data_o  (alu_sum)
  );

  fu_result_hold #(.DW(DW)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (kill_i),
    .cap_i      (cap),
    .cap_data_i (alu_sum),
    .shadow_ni  (shadow_ni),
    .wr_grant_i (wr_grant_i),
    .res_vld_o  (res_vld),
    .wr_req_o   (wr_req_o),
    .done_o     (done),
    .result_o   (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (kill_i || done) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (issue_go) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
    end else if (alu_in_valid && alu_in_ready) begin
      sent_q <= 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign rd_req_o = req;
  assign alu_a_o  = opnd[0];
  assign alu_b_o  = opnd[1];

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !busy_q && !kill_i |=> busy_q && rd_req_o == '1); // R1
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> rd_req_o == '0); // R2
  AST_WR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_grant_i |=> !busy_q && !wr_req_o); // R7
  AST_KILL_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !busy_q && rd_req_o == '0 && !wr_req_o); // R8
  AST_WR_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    got != '1 |-> !wr_req_o); // R4
endmodule

// File: tb/fu_handshake_ctrl_test.sv
module fu_handshake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0, kill_i = 1'b0, shadow_ni = 1'b1, wr_grant_i = 1'b0;
  logic [15:0] src_a_i = '0, src_b_i = '0;
  logic [1:0]  rd_grant_i = '0;
  logic        busy_o, wr_req_o;
  logic [1:0]  rd_req_o;
  logic [15:0] alu_a_o, alu_b_o, result_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fu_handshake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i), .kill_i(kill_i),
    .shadow_ni(shadow_ni), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .rd_grant_i(rd_grant_i), .wr_grant_i(wr_grant_i), .busy_o(busy_o),
    .rd_req_o(rd_req_o), .wr_req_o(wr_req_o), .alu_a_o(alu_a_o),
    .alu_b_o(alu_b_o), .result_o(result_o)
  );

  function automatic logic [15:0] exp_sum(input logic [15:0] a, input logic [15:0] b);
    return a + b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input int ga,
                        input int gb, input int sh, input int wg, input bit late_sh,
                        input int kill_at);
    bit ga_done = 0, gb_done = 0, pend_a = 0, pend_b = 0, prev_wr = 0, prev_sh = 1;
    bit fin = 0;
    int wcnt = 0;
    logic [15:0] exp = exp_sum(a, b);
    @(negedge clk);
    issue_i = 1; src_a_i = 16'($urandom); src_b_i = 16'($urandom);
    @(negedge clk);
    issue_i = 0;
    chk(busy_o == 1, "R1 busy", busy_o, 1);
    chk(rd_req_o == 2'b11, "R1 rd_req", rd_req_o, 3);
    for (int cyc = 0; cyc < 100; cyc++) begin
      if (pend_a) begin
        chk(rd_req_o[0] == 0, "R3 req A drop", rd_req_o[0], 0);
        chk(alu_a_o == a, "R3 latch A", alu_a_o, a);
        pend_a = 0;
      end
      if (pend_b) begin
        chk(rd_req_o[1] == 0, "R3 req B drop", rd_req_o[1], 0);
        chk(alu_b_o == b, "R3 latch B", alu_b_o, b);
        pend_b = 0;
      end
      if (!prev_sh && !prev_wr) chk(wr_req_o == 0, "R5 shadow block", wr_req_o, 0);
      if (prev_wr) chk(wr_req_o == 1, "R5 request kept", wr_req_o, 1);
      if (!(ga_done && gb_done)) chk(wr_req_o == 0, "R4 early write", wr_req_o, 0);
      if (cyc == kill_at) begin
        kill_i = 1; rd_grant_i = '0; wr_grant_i = 0; shadow_ni = 1;
        @(negedge clk);
        kill_i = 0;
        chk(busy_o == 0, "R8 busy", busy_o, 0);
        chk(rd_req_o == 0, "R8 rd_req", rd_req_o, 0);
        chk(wr_req_o == 0, "R8 wr_req", wr_req_o, 0);
        fin = 1;
        break;
      end
      rd_grant_i = '0;
      if (rd_req_o[0] && !ga_done && cyc >= ga) begin
        rd_grant_i[0] = 1; src_a_i = a; ga_done = 1; pend_a = 1;
      end else src_a_i = 16'($urandom);
      if (rd_req_o[1] && !gb_done && cyc >= gb) begin
        rd_grant_i[1] = 1; src_b_i = b; gb_done = 1; pend_b = 1;
      end else src_b_i = 16'($urandom);
      if (wr_req_o) wcnt++;
      shadow_ni  = wr_req_o ? !late_sh : (cyc >= sh);
      wr_grant_i = wr_req_o && wcnt > wg;
      #1;
      if (wr_grant_i) chk(result_o == exp, "R6 result", result_o, exp);
      else chk(result_o == 0, "R6 idle result", result_o, 0);
      prev_wr = wr_req_o && !wr_grant_i;
      prev_sh = shadow_ni;
      if (wr_grant_i) begin
        @(negedge clk);
        wr_grant_i = 0; rd_grant_i = '0; shadow_ni = 1;
        chk(busy_o == 0, "R7 busy", busy_o, 0);
        chk(wr_req_o == 0, "R7 wr_req", wr_req_o, 0);
        chk(rd_req_o == 0, "R2 idle rd_req", rd_req_o, 0);
        fin = 1;
        break;
      end
      @(negedge clk);
    end
    if (!fin) chk(0, "R7 completion", 0, 1);
    rd_grant_i = '0; wr_grant_i = 0; shadow_ni = 1;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(busy_o == 0, "R9 busy", busy_o, 0);
    chk(rd_req_o == 0, "R9 rd_req", rd_req_o, 0);
    chk(wr_req_o == 0, "R9 wr_req", wr_req_o, 0);
    chk(result_o == 0, "R9 result", result_o, 0);
    // directed
    run_op(16'h1234, 16'h0101, 0, 0, 0, 0, 0, -1);   // same-cycle grants
    run_op(16'hFFFF, 16'h0001, 3, 0, 0, 1, 0, -1);   // B first, wrap
    run_op(16'h0F00, 16'h00F0, 0, 4, 9, 0, 0, -1);   // A first, long shadow
    run_op(16'hAAAA, 16'h5555, 1, 1, 0, 3, 1, -1);   // shadow drops after request
    run_op(16'hDEAD, 16'hBEEF, 0, 0, 0, 2, 0, 5);    // kill with result held
    run_op(16'h0003, 16'h0004, 0, 0, 0, 0, 0, -1);   // no leak after kill
    run_op(16'h7777, 16'h1111, 0, 5, 0, 0, 0, 2);    // kill mid-read
    // kill and issue together while idle
    @(negedge clk);
    issue_i = 1; kill_i = 1;
    @(negedge clk);
    issue_i = 0; kill_i = 0;
    chk(busy_o == 0, "R8 issue dropped", busy_o, 0);
    chk(rd_req_o == 0, "R8 issue dropped rd_req", rd_req_o, 0);
    // random
    for (int k = 0; k < 60; k++) begin
      int kat;
      kat = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 8)) : -1;
      run_op(16'($urandom), 16'($urandom), int'($urandom_range(0, 4)),
             int'($urandom_range(0, 4)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), kat);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule